// File: doc/BRIEF.md
# Sliding-Sum Smoothing Edge Filter

This block smooths the pixels on both sides of a block edge in a video decoder's deblocking stage. One line of sixteen original samples across the edge is presented at a time. They are ordered from the far left sample `p7` through `p0`, then `q0` through the far right sample `q7`, and are 10 or 12 bits wide. The block returns the fourteen inner samples `p6` to `q6`, each either rewritten by a low-pass filter or passed through unchanged.

Two filter strengths are built in. The medium filter is 7-tap with a doubled centre and rewrites `p2` to `q2` from the window `p3`..`q3`. The wide filter is 15-tap with a doubled centre and rewrites `p6` to `q6` from the full window. Both compute their outputs from one running sum per filter. The first sum is built directly. Each later output drops two taps (the far outgoing tap and the sample just produced) and adds two (the next sample and the next far incoming tap). Taps that would fall outside a window repeat the outermost sample on that side. Every tap is an original, unfiltered sample. Which filter applies is set per line by two select bits from an external decision unit. The result is registered, one line per cycle, with one cycle of latency.

Top module: `edge_smooth_top`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid` and every bit of `pix_out` become 0.
- R2: `out_valid` is 1 exactly one cycle after a cycle with `in_valid` high. When `in_valid` is low, `pix_out` keeps its previous value.
- R3: With the medium filter in effect, output sample at input index i (i = 5..10, i.e. p2..q2) equals (sum of x[clamp(j,4,11)] for j = i-3..i+3, plus x[i], plus 4) >> 3. Taps outside the window therefore repeat p3 or q3.
- R4: With `sel_wide` set, output sample at input index i (i = 1..14) equals (sum of x[clamp(j,0,15)] for j = i-7..i+7, plus x[i], plus 8) >> 4. Taps outside the window therefore repeat p7 or q7.
- R5: With only `sel_med` set, outputs p6..p3 and q3..q6 equal their input samples.
- R6: With neither select set, all fourteen outputs equal their input samples.
- R7: When both selects are set, the wide result is used for all fourteen outputs.
- R8: No intermediate sum overflows: with every input at full scale (2^BD − 1), every filtered output is full scale.
- R9: Input sample index k (0 = p7, 7 = p0, 8 = q0, 15 = q7) occupies `pix_in[k*BD +: BD]`. Output index m (0 = p6, 13 = q6, carrying input index m+1) occupies `pix_out[m*BD +: BD]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A line of samples is presented |
| sel_med | input | 1 | Apply the medium filter to p2..q2 |
| sel_wide | input | 1 | Apply the wide filter to p6..q6 (wins over `sel_med`) |
| pix_in | input | 16*BD | Original samples p7..q7, p7 in the low bits |
| out_valid | output | 1 | `pix_out` holds a new line |
| pix_out | output | 14*BD | Resulting samples p6..q6, p6 in the low bits |

## Verification
Each filter mode is applied to a linear ramp, a hard step at the edge, alternating samples, a lone spike at p0, a scrambled line, all-zero and all-full-scale lines. The ramp and scrambled lines catch any wrong tap weight. The step places the nonzero samples on one side, so an error in edge replication or in which taps a running update adds or drops shows up at exact hand-computed values. The spike and alternating lines show whether the doubled centre tap follows the output position. Full scale exposes a sum too narrow to hold the peak total, and a line with both selects set tells apart which filter wins.

// File: rtl/edge_smooth_pkg.sv
package edge_smooth_pkg;
  localparam int NUM_TAPS   = 16;
  localparam int NUM_OUT    = NUM_TAPS - 2;
  localparam int MED_LO     = 4;
  localparam int MED_HI     = 11;
  localparam int MED_TAPS   = MED_HI - MED_LO + 1;
  localparam int MED_OUTS   = MED_TAPS - 2;
  localparam int MED_OFS    = MED_LO;
  localparam int MED_RAD    = 3;
  localparam int MED_SHIFT  = 3;
  localparam int WIDE_RAD   = 7;
  localparam int WIDE_SHIFT = 4;

  function automatic int clamp_idx(input int v, input int lo, input int hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction
endpackage

// File: rtl/sum_chain.sv
module sum_chain
  import edge_smooth_pkg::*;
#(
  parameter int BD    = 10,
  parameter int NPIX  = 16,
  parameter int RAD   = 7,
  parameter int SHIFT = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [BD-1:0] px  [NPIX],
  output logic [BD-1:0] res [NPIX-2]
);
  localparam int SW    = BD + SHIFT + 1;
  localparam int ROUND = 1 << (SHIFT - 1);

  logic [SW-1:0] sums [1:NPIX-2];

  // first output position (index 1): direct weighted sum
  always_comb begin
    logic [SW-1:0] acc;
    acc = SW'(ROUND) + SW'(px[1]);
    for (int j = 1 - RAD; j <= 1 + RAD; j++)
      acc = acc + SW'(px[clamp_idx(j, 0, NPIX - 1)]);
    sums[1] = acc;
  end

  for (genvar k = 2; k <= NPIX - 2; k++) begin : g_step
    localparam int DROP_FAR = clamp_idx(k - 1 - RAD, 0, NPIX - 1);
    localparam int ADD_FAR  = clamp_idx(k + RAD, 0, NPIX - 1);
    assign sums[k] = sums[k-1] - SW'(px[DROP_FAR]) - SW'(px[k-1])
                   + SW'(px[k]) + SW'(px[ADD_FAR]);
  end

  for (genvar k = 1; k <= NPIX - 2; k++) begin : g_out
    assign res[k-1] = sums[k][SHIFT +: BD];
    // R8: the top sum bit is headroom only; an average never reaches it
    a_r8_sum_fits: assert property (@(posedge clk) disable iff (rst)
      sums[k][SW-1] == 1'b0);
  end
endmodule

// File: rtl/out_select.sv
module out_select
  import edge_smooth_pkg::*;
#(
  parameter int BD = 10
) (
  input  logic          sel_med,
  input  logic          sel_wide,
  input  logic [BD-1:0] orig [NUM_OUT],
  input  logic [BD-1:0] med  [MED_OUTS],
  input  logic [BD-1:0] wide [NUM_OUT],
  output logic [BD-1:0] pick [NUM_OUT]
);
  // output m carries input index m+1; medium output n carries input MED_OFS+1+n
  localparam int MED_FIRST_OUT = MED_OFS;

  for (genvar m = 0; m < NUM_OUT; m++) begin : g_pick
    if (m >= MED_FIRST_OUT && m < MED_FIRST_OUT + MED_OUTS) begin : g_both
      assign pick[m] = sel_wide ? wide[m] :
                       sel_med  ? med[m - MED_FIRST_OUT] : orig[m];
    end else begin : g_wide_only
      assign pick[m] = sel_wide ? wide[m] : orig[m];
    end
  end
endmodule

// File: rtl/edge_smooth_top.sv
module edge_smooth_top
  import edge_smooth_pkg::*;
#(
  parameter int BD = 10
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  input  logic                  sel_med,
  input  logic                  sel_wide,
  input  logic [NUM_TAPS*BD-1:0] pix_in,
  output logic                  out_valid,
  output logic [NUM_OUT*BD-1:0] pix_out
);
  logic [BD-1:0] taps     [NUM_TAPS];
  logic [BD-1:0] med_taps [MED_TAPS];
  logic [BD-1:0] orig     [NUM_OUT];
  logic [BD-1:0] med_res  [MED_OUTS];
  logic [BD-1:0] wide_res [NUM_OUT];
  logic [BD-1:0] pick     [NUM_OUT];

  for (genvar k = 0; k < NUM_TAPS; k++) begin : g_unpack
    assign taps[k] = pix_in[k*BD +: BD];
  end
  for (genvar k = 0; k < MED_TAPS; k++) begin : g_med_win
    assign med_taps[k] = taps[MED_LO + k];
  end
  for (genvar m = 0; m < NUM_OUT; m++) begin : g_orig
    assign orig[m] = taps[m + 1];
  end

  sum_chain #(.BD(BD), .NPIX(MED_TAPS), .RAD(MED_RAD), .SHIFT(MED_SHIFT)) u_med (
    .clk (clk),
    .rst (rst),
    .px  (med_taps),
    .res (med_res)
  );

  sum_chain #(.BD(BD), .NPIX(NUM_TAPS), .RAD(WIDE_RAD), .SHIFT(WIDE_SHIFT)) u_wide (
    .clk (clk),
    .rst (rst),
    .px  (taps),
    .res (wide_res)
  );

  out_select #(.BD(BD)) u_sel (
    .sel_med  (sel_med),
    .sel_wide (sel_wide),
    .orig     (orig),
    .med      (med_res),
    .wide     (wide_res),
    .pick     (pick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      pix_out   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        for (int m = 0; m < NUM_OUT; m++) pix_out[m*BD +: BD] <= pick[m];
      end
    end
  end

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    out_valid == $past(in_valid && !rst));

  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    (!$past(in_valid) && !$past(rst)) |-> $stable(pix_out));

  a_r6_passthrough: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !$past(sel_med) && !$past(sel_wide))
      |-> pix_out == $past(pix_in[BD +: NUM_OUT*BD]));

  a_r5_outer_kept: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(sel_med) && !$past(sel_wide))
      |-> (pix_out[0 +: 4*BD] == $past(pix_in[BD +: 4*BD]) &&
           pix_out[10*BD +: 4*BD] == $past(pix_in[11*BD +: 4*BD])));
endmodule

// File: tb/sim_edge_smooth_top.sv
module sim_edge_smooth_top;
  localparam int BD   = 10;
  localparam int NT   = 16;
  localparam int NO   = 14;
  localparam int FULL = (1 << BD) - 1;

  // each entry: pattern*4 + wide*2 + med
  localparam int NVEC = 16;
  localparam int VEC [NVEC] = '{
    0*4+0, 0*4+1, 0*4+2, 0*4+3,
    1*4+1, 1*4+2, 2*4+1, 2*4+2,
    3*4+1, 3*4+2, 4*4+1, 4*4+2,
    5*4+1, 5*4+2, 5*4+3, 6*4+2
  };

  logic clk = 0;
  logic rst = 1;
  logic in_valid = 0, sel_med = 0, sel_wide = 0;
  logic [NT*BD-1:0] pix_in = '0;
  logic out_valid;
  logic [NO*BD-1:0] pix_out;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  edge_smooth_top #(.BD(BD)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .sel_med(sel_med),
    .sel_wide(sel_wide), .pix_in(pix_in), .out_valid(out_valid), .pix_out(pix_out)
  );

  function automatic logic [NT*BD-1:0] gen_pix(input int kind);
    logic [NT*BD-1:0] v;
    for (int k = 0; k < NT; k++) begin
      int s;
      case (kind)
        0: s = 40 * k + 17;
        1: s = (k < 8) ? 0 : FULL;
        2: s = FULL;
        3: s = (k % 2) ? 900 : 100;
        4: s = (k == 7) ? 1000 : 50;
        5: s = (k * 337 + 91) % (FULL + 1);
        default: s = 0;
      endcase
      v[k*BD +: BD] = BD'(s);
    end
    return v;
  endfunction

  function automatic int cl(input int v, input int lo, input int hi);
    return (v < lo) ? lo : (v > hi) ? hi : v;
  endfunction

  function automatic logic [NO*BD-1:0] ref_out(input logic [NT*BD-1:0] p,
                                               input bit w, input bit m);
    logic [NO*BD-1:0] r;
    for (int o = 0; o < NO; o++) begin
      int i = o + 1;
      int s;
      s = int'(p[i*BD +: BD]);
      if (w) begin
        int acc = 8 + int'(p[i*BD +: BD]);
        for (int j = i - 7; j <= i + 7; j++) acc += int'(p[cl(j, 0, 15)*BD +: BD]);
        s = acc >> 4;
      end else if (m && i >= 5 && i <= 10) begin
        int acc = 4 + int'(p[i*BD +: BD]);
        for (int j = i - 3; j <= i + 3; j++) acc += int'(p[cl(j, 4, 11)*BD +: BD]);
        s = acc >> 3;
      end
      r[o*BD +: BD] = BD'(s);
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_vec(input string req, input logic [NO*BD-1:0] exp);
    checks++;
    if (pix_out !== exp || out_valid !== 1'b1) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h valid=%b", req, pix_out, exp, out_valid);
    end
  endtask

  task automatic apply(input logic [NT*BD-1:0] p, input bit w, input bit m);
    @(negedge clk);
    pix_in = p; sel_wide = w; sel_med = m; in_valid = 1;
    @(negedge clk);
    in_valid = 0;
  endtask

  function automatic string mode_req(input bit w, input bit m);
    if (w && m) return "R7 both selects";
    if (w) return "R4 wide";
    if (m) return "R3 R5 medium";
    return "R6 none";
  endfunction

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [NO*BD-1:0] held;
    repeat (5) @(negedge clk);
    // R1: reset state
    check(out_valid === 1'b0, "R1 out_valid in reset", out_valid, 0);
    check(pix_out === '0, "R1 pix_out in reset", pix_out, 0);
    rst = 0;
    @(negedge clk);
    check(out_valid === 1'b0, "R1 out_valid after reset", out_valid, 0);

    // table of patterns and modes
    for (int v = 0; v < NVEC; v++) begin
      logic [NT*BD-1:0] p = gen_pix(VEC[v] / 4);
      bit w = VEC[v][1];
      bit m = VEC[v][0];
      apply(p, w, m);
      check_vec(mode_req(w, m), ref_out(p, w, m));
    end

    // R3 R9: hand values on a step, medium
    apply(gen_pix(1), 0, 1);
    check(pix_out[4*BD +: BD] == 128, "R3 R9 step p2", pix_out[4*BD +: BD], 128);
    check(pix_out[9*BD +: BD] == 895, "R3 R9 step q2", pix_out[9*BD +: BD], 895);
    check(pix_out[3*BD +: BD] == 0, "R5 step p3 kept", pix_out[3*BD +: BD], 0);
    // R4 R9: hand values on a step, wide
    apply(gen_pix(1), 1, 0);
    check(pix_out[0 +: BD] == 64, "R4 R9 step p6", pix_out[0 +: BD], 64);
    check(pix_out[13*BD +: BD] == 959, "R4 R9 step q6", pix_out[13*BD +: BD], 959);
    // R7: both set on a step gives the wide value at p6
    apply(gen_pix(1), 1, 1);
    check(pix_out[0 +: BD] == 64, "R7 step p6 wide wins", pix_out[0 +: BD], 64);

    // R8: full scale through both filters
    apply(gen_pix(2), 1, 0);
    for (int o = 0; o < NO; o++)
      check(pix_out[o*BD +: BD] == FULL, "R8 wide full scale", pix_out[o*BD +: BD], FULL);
    apply(gen_pix(2), 0, 1);
    check(pix_out[6*BD +: BD] == FULL, "R8 medium full scale", pix_out[6*BD +: BD], FULL);
    apply(gen_pix(6), 1, 0);
    check(pix_out == '0, "R4 all zero", pix_out, 0);

    // R2: valid drops, output holds while in_valid low
    apply(gen_pix(0), 1, 0);
    held = pix_out;
    @(negedge clk);
    pix_in = gen_pix(5); sel_med = 1; sel_wide = 0;
    @(negedge clk);
    check(out_valid === 1'b0, "R2 out_valid low when idle", out_valid, 0);
    check(pix_out === held, "R2 hold when idle", pix_out, held);

    // R1: reset mid-stream clears outputs
    rst = 1;
    @(negedge clk);
    check(pix_out === '0 && out_valid === 1'b0, "R1 reset clears", pix_out, 0);
    rst = 0;

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule